// File: doc/BRIEF.md
# Store-to-Load Overlap Comparator

This block keeps the address description of the latest store issued in the current dispatch group. For each load candidate it decides, in the same cycle, whether that load may read bytes the store writes. A scheduler uses the answer to keep a load out of the store's group. An address is described by two operands: an offset (or index) operand and a base operand. Each operand is a flag that marks it as a known constant, plus a 16-bit payload. The payload is a symbolic tag when the flag is clear and a signed constant value when it is set.

A store-issue strobe records the store's two operands and its access width. A group-clear strobe empties the record. The load query is purely combinational against the recorded state. No real address is formed. Matching works on operand identity and, where both offsets are constants on a shared base, on byte ranges.

Top module: `stlo_cmp`

## Requirements
- R1: With a store recorded, `ld_hit` is 1 when the load offset operand equals the recorded offset operand and the load base operand equals the recorded base operand.
- R2: With a store recorded, `ld_hit` is 1 in the swapped pairing: the load offset equals the recorded base and the load base equals the recorded offset.
- R3: When the bases are equal, both offsets are constants and the store offset is below the load offset, `ld_hit` is 1 exactly when store offset plus store bytes is greater than the load offset.
- R4: When the bases are equal, both offsets are constants and the store offset is not below the load offset, `ld_hit` is 1 exactly when load offset plus load bytes is greater than the store offset.
- R5: The width inputs `st_wide` and `ld_wide` select 4 bytes when 0 and 8 bytes when 1.
- R6: After reset or after `grp_clr`, nothing is recorded and `ld_hit` stays 0 for every load.
- R7: A new store replaces the recorded operands and width, so a load that matched only the older store no longer hits.
- R8: When `grp_clr` and `st_issue` are high in the same cycle, the clear wins and nothing is recorded.
- R9: Constant offsets are signed 16-bit values. Sums are formed wide enough that an offset near +32767 or -32768 plus 8 bytes never wraps.
- R10: Two operands are equal only when their constant flags agree and their 16-bit payloads are equal. A tag never equals a constant that has the same payload.
- R11: A store is captured on the clock edge where `st_issue` is high. A load queried in that same cycle is compared against the previous record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grp_clr | input | 1 | Empties the store record at the next edge |
| st_issue | input | 1 | Records the store operands and width at the next edge |
| st_off_k | input | 1 | Store offset operand is a constant |
| st_off_v | input | 16 | Store offset payload (tag or signed value) |
| st_base_k | input | 1 | Store base operand is a constant |
| st_base_v | input | 16 | Store base payload |
| st_wide | input | 1 | Store width: 0 = 4 bytes, 1 = 8 bytes |
| ld_off_k | input | 1 | Load offset operand is a constant |
| ld_off_v | input | 16 | Load offset payload |
| ld_base_k | input | 1 | Load base operand is a constant |
| ld_base_v | input | 16 | Load base payload |
| ld_wide | input | 1 | Load width: 0 = 4 bytes, 1 = 8 bytes |
| ld_hit | output | 1 | Load may overlap the recorded store |

## Verification
A corrupted record shows at the ports on the first load query after the bad capture. A lost store, a stale operand or a wrong width makes `ld_hit` wrong for a load aimed at the true store. A record that survives clear makes `ld_hit` rise for a load that should be free. Several constant offsets sit exactly on range boundaries and at the signed extremes. An off-by-one compare, a narrow adder or an unsigned compare therefore flips a single query result. Same-cycle issue-and-query and clear-and-issue cycles expose a wrong capture timing or a wrong strobe priority.

// File: rtl/stlo_pkg.sv
// Shared constants and operand type for the store-to-load overlap comparator.
// Assumes 16-bit operand payloads and the two access widths of 4 and 8 bytes.
package stlo_pkg;
    parameter int PAY_W      = 16;
    parameter int NARROW_B   = 4;
    parameter int WIDE_B     = 8;
    parameter int BYTES_W    = $clog2(WIDE_B + 1);
    parameter int SUM_W      = PAY_W + 2;

    typedef struct packed {
        logic             is_k;
        logic [PAY_W-1:0] pay;
    } opnd_t;

    function automatic logic [BYTES_W-1:0] width_bytes(input logic wide);
        return wide ? BYTES_W'(WIDE_B) : BYTES_W'(NARROW_B);
    endfunction
endpackage

// File: rtl/stlo_opnd_eq.sv
// Operand identity compare. Two operands are the same only when both are
// constants or both are tags, and the payloads agree.
module stlo_opnd_eq
    import stlo_pkg::*;
(
    input  opnd_t a,
    input  opnd_t b,
    output logic  same
);
    // Flag and payload must both agree.
    always_comb begin
        same = (a.is_k == b.is_k) && (a.pay == b.pay);
    end
endmodule

// File: rtl/stlo_range_chk.sv
// Byte-range overlap of two constant offsets on a shared base.
// Assumes the caller has already checked that both offsets are constants.
// Arithmetic is sign-extended by two bits so offset plus width never wraps.
module stlo_range_chk
    import stlo_pkg::*;
(
    input  logic [PAY_W-1:0]   st_off,
    input  logic [BYTES_W-1:0] st_bytes,
    input  logic [PAY_W-1:0]   ld_off,
    input  logic [BYTES_W-1:0] ld_bytes,
    output logic               overlap
);
    logic signed [SUM_W-1:0] st_s;
    logic signed [SUM_W-1:0] ld_s;
    logic signed [SUM_W-1:0] st_end;
    logic signed [SUM_W-1:0] ld_end;

    // Widen both offsets and form the exclusive end of each access.
    always_comb begin
        st_s   = $signed({{(SUM_W-PAY_W){st_off[PAY_W-1]}}, st_off});
        ld_s   = $signed({{(SUM_W-PAY_W){ld_off[PAY_W-1]}}, ld_off});
        st_end = st_s + $signed({{(SUM_W-BYTES_W){1'b0}}, st_bytes});
        ld_end = ld_s + $signed({{(SUM_W-BYTES_W){1'b0}}, ld_bytes});
    end

    // The lower access must reach past the start of the higher one.
    always_comb begin
        if (st_s < ld_s) overlap = (st_end > ld_s);
        else             overlap = (ld_end > st_s);
    end
endmodule

// File: rtl/stlo_store_rec.sv
// Holds the latest store of the group: two operands and the byte count.
// A byte count of zero means nothing is recorded. Clear wins over issue.
module stlo_store_rec
    import stlo_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               grp_clr,
    input  logic               st_issue,
    input  opnd_t              st_off,
    input  opnd_t              st_base,
    input  logic               st_wide,
    output opnd_t              rec_off,
    output opnd_t              rec_base,
    output logic [BYTES_W-1:0] rec_bytes,
    output logic               rec_valid
);
    // Capture or empty the record on the clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n || grp_clr) begin
            rec_off   <= '0;
            rec_base  <= '0;
            rec_bytes <= '0;
        end else if (st_issue) begin
            rec_off   <= st_off;
            rec_base  <= st_base;
            rec_bytes <= width_bytes(st_wide);
        end
    end

    // A nonzero byte count marks a recorded store.
    always_comb begin
        rec_valid = (rec_bytes != '0);
    end

    p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        grp_clr |=> (rec_bytes == '0));

    p_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_issue && !grp_clr) |=>
            (rec_off == $past(st_off)) && (rec_base == $past(st_base)) &&
            (rec_bytes == ($past(st_wide) ? BYTES_W'(WIDE_B) : BYTES_W'(NARROW_B))));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_issue && !grp_clr) |=> $stable(rec_bytes) && $stable(rec_off) && $stable(rec_base));
endmodule

// File: rtl/stlo_cmp.sv
// Store-to-load overlap comparator top. Compares a load's two operands
// against the recorded store in straight and swapped order, and checks the
// byte ranges when both offsets are constants on the same base.
// Assumes ld_* inputs are stable while ld_hit is consumed.
module stlo_cmp
    import stlo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grp_clr,
    input  logic             st_issue,
    input  logic             st_off_k,
    input  logic [PAY_W-1:0] st_off_v,
    input  logic             st_base_k,
    input  logic [PAY_W-1:0] st_base_v,
    input  logic             st_wide,
    input  logic             ld_off_k,
    input  logic [PAY_W-1:0] ld_off_v,
    input  logic             ld_base_k,
    input  logic [PAY_W-1:0] ld_base_v,
    input  logic             ld_wide,
    output logic             ld_hit
);
    localparam int N_CMP = 4;

    opnd_t              st_off, st_base, ld_off, ld_base;
    opnd_t              rec_off, rec_base;
    logic [BYTES_W-1:0] rec_bytes;
    logic               rec_valid;
    logic               range_hit;
    logic               straight, swapped, ranged;
    opnd_t              cmp_a [N_CMP];
    opnd_t              cmp_b [N_CMP];
    logic [N_CMP-1:0]   eq;

    // Pack the flat ports into operand records.
    always_comb begin
        st_off  = '{is_k: st_off_k,  pay: st_off_v};
        st_base = '{is_k: st_base_k, pay: st_base_v};
        ld_off  = '{is_k: ld_off_k,  pay: ld_off_v};
        ld_base = '{is_k: ld_base_k, pay: ld_base_v};
    end

    stlo_store_rec u_rec (
        .clk       (clk),
        .rst_n     (rst_n),
        .grp_clr   (grp_clr),
        .st_issue  (st_issue),
        .st_off    (st_off),
        .st_base   (st_base),
        .st_wide   (st_wide),
        .rec_off   (rec_off),
        .rec_base  (rec_base),
        .rec_bytes (rec_bytes),
        .rec_valid (rec_valid)
    );

    // Pairings: 0 off/off, 1 base/base, 2 off/base, 3 base/off.
    always_comb begin
        cmp_a[0] = ld_off;  cmp_b[0] = rec_off;
        cmp_a[1] = ld_base; cmp_b[1] = rec_base;
        cmp_a[2] = ld_off;  cmp_b[2] = rec_base;
        cmp_a[3] = ld_base; cmp_b[3] = rec_off;
    end

    for (genvar gi = 0; gi < N_CMP; gi++) begin : g_eq
        stlo_opnd_eq u_eq (
            .a    (cmp_a[gi]),
            .b    (cmp_b[gi]),
            .same (eq[gi])
        );
    end

    stlo_range_chk u_range (
        .st_off   (rec_off.pay),
        .st_bytes (rec_bytes),
        .ld_off   (ld_off_v),
        .ld_bytes (width_bytes(ld_wide)),
        .overlap  (range_hit)
    );

    // Combine the three match paths, gated by a recorded store.
    always_comb begin
        straight = eq[0] && eq[1];
        swapped  = eq[2] && eq[3];
        ranged   = eq[1] && rec_off.is_k && ld_off_k && range_hit;
        ld_hit   = rec_valid && (straight || swapped || ranged);
    end

    p_empty_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_valid |-> !ld_hit);

    p_straight_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && eq[0] && eq[1]) |-> ld_hit);

    p_swapped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && eq[2] && eq[3]) |-> ld_hit);

    p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid && eq[1] && rec_off.is_k && ld_off_k && range_hit) |-> ld_hit);
endmodule

// File: tb/stlo_cmp_tb.sv
`timescale 1ns/1ps
module stlo_cmp_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        grp_clr = 1'b0, st_issue = 1'b0;
    logic        st_off_k = 1'b0, st_base_k = 1'b0, st_wide = 1'b0;
    logic [15:0] st_off_v = '0, st_base_v = '0;
    logic        ld_off_k = 1'b0, ld_base_k = 1'b0, ld_wide = 1'b0;
    logic [15:0] ld_off_v = '0, ld_base_v = '0;
    logic        ld_hit;

    typedef struct { bit exp; string req; } item_t;
    item_t sb_q[$];
    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    stlo_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .grp_clr(grp_clr), .st_issue(st_issue),
        .st_off_k(st_off_k), .st_off_v(st_off_v), .st_base_k(st_base_k),
        .st_base_v(st_base_v), .st_wide(st_wide),
        .ld_off_k(ld_off_k), .ld_off_v(ld_off_v), .ld_base_k(ld_base_k),
        .ld_base_v(ld_base_v), .ld_wide(ld_wide), .ld_hit(ld_hit)
    );

    // Monitor: pop one expectation per cycle, sampled mid-cycle.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (ld_hit !== it.exp) begin
                n_err++;
                $display("FAIL %s: ld_hit=%b expected=%b", it.req, ld_hit, it.exp);
            end
        end
    end

    task automatic set_st(input bit ok, input int ov, input bit bk, input int bv, input bit w);
        st_off_k = ok; st_off_v = 16'(ov); st_base_k = bk; st_base_v = 16'(bv); st_wide = w;
    endtask

    task automatic set_ld(input bit ok, input int ov, input bit bk, input int bv, input bit w);
        ld_off_k = ok; ld_off_v = 16'(ov); ld_base_k = bk; ld_base_v = 16'(bv); ld_wide = w;
    endtask

    // Record a store; it is visible from the following cycle.
    task automatic do_store(input bit ok, input int ov, input bit bk, input int bv, input bit w);
        set_st(ok, ov, bk, bv, w);
        st_issue = 1'b1;
        @(posedge clk); #1;
        st_issue = 1'b0;
    endtask

    // Drive a load and push its expected hit.
    task automatic query(input bit ok, input int ov, input bit bk, input int bv, input bit w,
                         input bit exp, input string req);
        set_ld(ok, ov, bk, bv, w);
        sb_q.push_back('{exp: exp, req: req});
        @(posedge clk); #1;
    endtask

    task automatic do_clear();
        grp_clr = 1'b1;
        @(posedge clk); #1;
        grp_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R6: empty after reset
        query(0, 7, 0, 5, 0, 1'b0, "R6 reset empty");
        do_store(0, 7, 0, 5, 0);
        query(0, 7, 0, 5, 0, 1'b1, "R1 straight pair");
        query(0, 7, 0, 6, 0, 1'b0, "R1 base differs");
        query(0, 5, 0, 7, 0, 1'b1, "R2 swapped pair");
        query(1, 7, 0, 5, 0, 1'b0, "R10 const vs tag same payload");
        // Constant offsets on tag base 9
        do_store(1, 0, 0, 9, 1);
        query(1, 4, 0, 9, 0, 1'b1, "R3 8B store reaches load at 4");
        query(1, 2, 0, 8, 0, 1'b0, "R3 other base no range");
        query(1, 0, 0, 9, 0, 1'b1, "R1 const pair equal");
        do_store(1, 0, 0, 9, 0);
        query(1, 4, 0, 9, 0, 1'b0, "R5 4B store ends at 4");
        query(1, -2, 0, 9, 0, 1'b1, "R4 load -2 4B reaches 0");
        query(1, -4, 0, 9, 0, 1'b0, "R4 load -4 4B ends at 0");
        query(1, -4, 0, 9, 1, 1'b1, "R5 load -4 8B reaches 0");
        // Signed extremes
        do_store(1, 32764, 0, 9, 1);
        query(1, 32767, 0, 9, 0, 1'b1, "R9 store end past +32767");
        do_store(1, -32768, 0, 9, 1);
        query(1, 32767, 0, 9, 0, 1'b0, "R9 store at -32768 far below");
        do_store(1, 32767, 0, 9, 0);
        query(1, -32768, 0, 9, 1, 1'b0, "R9 load at -32768 far below");
        // R7: overwrite
        do_store(0, 7, 0, 5, 0);
        do_store(0, 1, 0, 2, 0);
        query(0, 7, 0, 5, 0, 1'b0, "R7 older store forgotten");
        query(0, 1, 0, 2, 0, 1'b1, "R7 newest store kept");
        // R11: same-cycle issue and query sees the old record
        set_st(0, 3, 0, 4, 0);
        st_issue = 1'b1;
        query(0, 3, 0, 4, 0, 1'b0, "R11 query in capture cycle");
        st_issue = 1'b0;
        query(0, 3, 0, 4, 0, 1'b1, "R11 query after capture");
        // R6: clear
        do_clear();
        query(0, 3, 0, 4, 0, 1'b0, "R6 after clear");
        // R8: clear and issue together
        do_store(0, 3, 0, 4, 0);
        set_st(0, 3, 0, 4, 0);
        st_issue = 1'b1; grp_clr = 1'b1;
        @(posedge clk); #1;
        st_issue = 1'b0; grp_clr = 1'b0;
        query(0, 3, 0, 4, 0, 1'b0, "R8 clear beats issue");
        @(posedge clk); #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #50000;
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule